// File: doc/BRIEF.md
# Converter Start Trigger Selector

This block decides the clock cycle in which an analog-to-digital converter sequencer begins a conversion. Each converter has a configuration write port that carries a 3-bit start code, a polarity bit and a burst flag. The block holds these values and turns them into a single-cycle start pulse for that converter's sequencer. A start can fire as soon as the configuration is written, or later on a chosen edge of one of six trigger sources. Two of these sources are asynchronous pins and four are on-chip timer match signals.

A global write port loads the same configuration into every converter in one cycle, so that converters can be started together. Pin sources pass through a synchroniser before edge detection. Match sources are already on the system clock and are sampled directly. The selected source is XORed with the polarity bit and then fed to a single rising-edge detector. The previous-value register of that detector reloads on every configuration write, so changing the selection cannot produce a false trigger. While burst mode is set, no start of any kind is issued. External edges that arrive while the converter reports busy are dropped and are not queued.

Top module: `adc_start_trigger`

## Requirements
- R1: During and after reset, every bit of start_pulse is 0 and every converter holds start code 000.
- R2: Start code 000 never produces a start pulse, whatever the trigger sources do.
- R3: A write of start code 001 with burst clear produces exactly one start pulse for that converter, in the cycle after the write, and affects no other converter.
- R4: Start codes select their edge source in this order: 010 pin 0, 011 pin 1, 100 match bit 0, 101 match bit 1, 110 match bit 2, 111 match bit 3. Activity on sources that are not selected produces no pulse.
- R5: For codes 010 to 111, polarity 0 fires on a rising edge of the selected source and polarity 1 fires on a falling edge. The opposite edge produces no pulse.
- R6: While the burst flag is set, no start pulse is produced for any start code, including 001.
- R7: A global write loads the start code, polarity and burst flag into every converter in the same cycle. With code 001 and burst clear, every start_pulse bit rises in the cycle after that write. A global write takes priority over a per-converter write in the same cycle.
- R8: An edge on a pin source gives a start pulse three cycles after the first clock edge that samples it, because of two synchroniser stages and the output register. An edge on a match source gives a pulse one cycle after the sampling clock edge.
- R9: A configuration write never produces an edge-triggered pulse, even if the newly selected source, after polarity, is already high.
- R10: An edge of the selected source that arrives while conv_busy is high produces no pulse, then or after busy falls.
- R11: The polarity bit has no effect on code 001: a write of 001 with polarity 1 still starts a conversion.
- R12: Each qualifying edge or immediate write gives a pulse exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | NUM_CONV | Per-converter configuration write strobe |
| cfg_code | input | NUM_CONV*3 | Start code for each converter; converter i uses bits [3i+2:3i] |
| cfg_fall | input | NUM_CONV | Polarity for each converter (1 = falling edge) |
| cfg_burst | input | NUM_CONV | Burst flag for each converter |
| gs_wr | input | 1 | Global write strobe that loads every converter |
| gs_code | input | 3 | Start code for the global write |
| gs_fall | input | 1 | Polarity for the global write |
| gs_burst | input | 1 | Burst flag for the global write |
| pin_async | input | 2 | Asynchronous pin trigger sources |
| match_in | input | 4 | Timer match trigger sources, synchronous to clk |
| conv_busy | input | NUM_CONV | Each converter reports a conversion in progress |
| start_pulse | output | NUM_CONV | Single-cycle conversion start for each converter |

## Verification
The bench writes a new selection while the new source, after polarity, is already high. A design that does not reload the previous-value register would fire a false start there. Each source is exercised while its neighbours toggle, and both polarities are driven in both directions, so an off-by-one in the code-to-source map or an inverted XOR shows up as a missing pulse or an extra one. Busy and burst are checked both while the edge is present and after they clear, which catches a design that stores a trigger and replays it later. Pin edges are checked at exactly three cycles, which catches a synchroniser stage that is missing or added.

// File: rtl/adc_trig_pkg.sv
// Package: shared constants and types for the conversion start selector.
// Assumes a 3-bit start code: two codes are reserved (none and immediate),
// and the remaining codes each select one edge source.
package adc_trig_pkg;

    localparam int TRIG_CODE_W = 3;
    localparam int TRIG_SRC_N  = (1 << TRIG_CODE_W) - 2;
    localparam int TRIG_PIN_N  = 2;
    localparam int TRIG_MATCH_N = TRIG_SRC_N - TRIG_PIN_N;

    typedef enum logic [TRIG_CODE_W-1:0] {
        TRG_NONE   = 3'b000,
        TRG_NOW    = 3'b001,
        TRG_PIN_A  = 3'b010,
        TRG_PIN_B  = 3'b011,
        TRG_MATCH0 = 3'b100,
        TRG_MATCH1 = 3'b101,
        TRG_MATCH2 = 3'b110,
        TRG_MATCH3 = 3'b111
    } trig_code_e;

    typedef struct packed {
        trig_code_e code;
        logic       fall_sel;
        logic       burst;
    } trig_cfg_t;

endpackage

// File: rtl/adc_trig_sync.sv
// Module: multi-bit, multi-stage synchroniser for asynchronous trigger pins.
// Assumes each bit is an independent level signal. No bus coherence is implied.
module adc_trig_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Purpose: shift each pin level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/adc_trig_chan.sv
// Module: per-converter start logic. It holds the configuration, picks the
// edge source, applies polarity by XOR, and detects a rising edge.
// Assumes src_i is synchronous to clk. The write strobe has already been
// merged with the global write by the parent.
module adc_trig_chan
    import adc_trig_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  trig_cfg_t             cfg_i,
    input  logic [TRIG_SRC_N-1:0] src_i,
    input  logic                  busy_i,
    output logic                  start_o
);

    trig_cfg_t cfg_q;
    logic      prev_q;
    logic      cur_lvl;
    logic      load_lvl;
    logic      ext_sel;
    logic      fire;

    // Purpose: return the chosen source after polarity, or 0 for the two non-edge codes.
    function automatic logic src_pick(input trig_cfg_t c, input logic [TRIG_SRC_N-1:0] s);
        logic [TRIG_CODE_W-1:0] idx;
        idx = c.code - TRG_PIN_A;
        if (c.code >= TRG_PIN_A) return s[idx] ^ c.fall_sel;
        return 1'b0;
    endfunction

    // Purpose: levels for the stored configuration and for the one being written.
    always_comb begin
        cur_lvl  = src_pick(cfg_q, src_i);
        load_lvl = src_pick(cfg_i, src_i);
        ext_sel  = (cfg_q.code >= TRG_PIN_A);
    end

    // Purpose: decide whether a start is issued this cycle.
    always_comb begin
        if (wr_i) begin
            fire = (cfg_i.code == TRG_NOW) && !cfg_i.burst;
        end else begin
            fire = ext_sel && !cfg_q.burst && !busy_i && cur_lvl && !prev_q;
        end
    end

    // Purpose: hold the configuration and edge history, and register the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '{code: TRG_NONE, fall_sel: 1'b0, burst: 1'b0};
            prev_q  <= 1'b0;
            start_o <= 1'b0;
        end else begin
            if (wr_i) begin
                cfg_q  <= cfg_i;
                prev_q <= load_lvl;
            end else begin
                prev_q <= cur_lvl;
            end
            start_o <= fire;
        end
    end

    p_no_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.code == TRG_NONE && !wr_i) |=> !start_o);

    p_imm_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && cfg_i.code == TRG_NOW && !cfg_i.burst) |=> start_o);

    p_burst_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_q.burst && !wr_i) || (wr_i && cfg_i.burst)) |=> !start_o);

    p_write_no_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && cfg_i.code != TRG_NOW) |=> !start_o);

    p_busy_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !wr_i) |=> !start_o);

    p_one_wide_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && !wr_i) |=> !start_o);

endmodule

// File: rtl/adc_start_trigger.sv
// Module: top of the start selector. It merges the per-converter and global
// writes, synchronises the pin sources, and builds one channel per converter.
// Assumes match_in is already synchronous to clk and pin_async is not.
module adc_start_trigger
    import adc_trig_pkg::*;
#(
    parameter int NUM_CONV    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_CONV-1:0]             cfg_wr,
    input  logic [NUM_CONV*TRIG_CODE_W-1:0] cfg_code,
    input  logic [NUM_CONV-1:0]             cfg_fall,
    input  logic [NUM_CONV-1:0]             cfg_burst,
    input  logic                            gs_wr,
    input  logic [TRIG_CODE_W-1:0]          gs_code,
    input  logic                            gs_fall,
    input  logic                            gs_burst,
    input  logic [TRIG_PIN_N-1:0]           pin_async,
    input  logic [TRIG_MATCH_N-1:0]         match_in,
    input  logic [NUM_CONV-1:0]             conv_busy,
    output logic [NUM_CONV-1:0]             start_pulse
);

    logic [TRIG_PIN_N-1:0] pin_sync;
    logic [TRIG_SRC_N-1:0] src_vec;

    adc_trig_sync #(
        .WIDTH  (TRIG_PIN_N),
        .STAGES (SYNC_STAGES)
    ) pin_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_async),
        .sync_o  (pin_sync)
    );

    // Purpose: order the sources so that the code offset indexes them directly.
    assign src_vec = {match_in, pin_sync};

    for (genvar g = 0; g < NUM_CONV; g++) begin : g_conv
        logic      wr_any;
        trig_cfg_t cfg_sel;

        // Purpose: the global write wins over a per-converter write in the same cycle.
        always_comb begin
            wr_any = cfg_wr[g] | gs_wr;
            if (gs_wr) begin
                cfg_sel = '{code: trig_code_e'(gs_code), fall_sel: gs_fall, burst: gs_burst};
            end else begin
                cfg_sel = '{code: trig_code_e'(cfg_code[g*TRIG_CODE_W +: TRIG_CODE_W]),
                            fall_sel: cfg_fall[g], burst: cfg_burst[g]};
            end
        end

        adc_trig_chan chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (wr_any),
            .cfg_i   (cfg_sel),
            .src_i   (src_vec),
            .busy_i  (conv_busy[g]),
            .start_o (start_pulse[g])
        );
    end

    p_global_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gs_wr && gs_code == TRG_NOW && !gs_burst) |=> (&start_pulse));

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (start_pulse == '0));

endmodule

// File: tb/adc_start_trigger_tb_top.sv
module adc_start_trigger_tb_top;

    localparam int NC = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NC-1:0]   cfg_wr = '0;
    logic [NC*3-1:0] cfg_code = '0;
    logic [NC-1:0]   cfg_fall = '0;
    logic [NC-1:0]   cfg_burst = '0;
    logic            gs_wr = 1'b0;
    logic [2:0]      gs_code = '0;
    logic            gs_fall = 1'b0;
    logic            gs_burst = 1'b0;
    logic [1:0]      pin_async = '0;
    logic [3:0]      match_in = '0;
    logic [NC-1:0]   conv_busy = '0;
    logic [NC-1:0]   start_pulse;

    adc_start_trigger dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_code(cfg_code),
        .cfg_fall(cfg_fall), .cfg_burst(cfg_burst), .gs_wr(gs_wr),
        .gs_code(gs_code), .gs_fall(gs_fall), .gs_burst(gs_burst),
        .pin_async(pin_async), .match_in(match_in), .conv_busy(conv_busy),
        .start_pulse(start_pulse)
    );

    always #10 clk = ~clk;

    typedef struct {
        int            cyc;
        logic [NC-1:0] val;
        string         req;
    } exp_t;

    exp_t  exp_q[$];
    int    cyc = 0;
    int    compared = 0;
    int    mismatched = 0;
    string ctx = "R1";
    bit    done = 1'b0;
    logic [NC-1:0] mon_exp;
    string mon_req;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every cycle against the scoreboard; a cycle with no item expects no pulse.
    always @(negedge clk) begin
        if (!done) begin
            if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
                mon_exp = exp_q[0].val;
                mon_req = exp_q[0].req;
                void'(exp_q.pop_front());
            end else begin
                mon_exp = '0;
                mon_req = ctx;
            end
            compared++;
            if (start_pulse !== mon_exp) begin
                mismatched++;
                $display("FAIL %s cycle %0d: start_pulse=%b expected=%b", mon_req, cyc, start_pulse, mon_exp);
            end
        end
    end

    task automatic push(int at, logic [NC-1:0] v, string r);
        exp_t e;
        e.cyc = at; e.val = v; e.req = r;
        exp_q.push_back(e);
    endtask

    task automatic idle(int n, string r);
        ctx = r;
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_conv(int i, logic [2:0] code, logic f, logic b, logic [NC-1:0] ex, string r);
        @(negedge clk);
        ctx = r;
        cfg_wr[i] = 1'b1;
        cfg_code[i*3 +: 3] = code;
        cfg_fall[i] = f;
        cfg_burst[i] = b;
        if (ex != '0) push(cyc + 1, ex, r);
        @(negedge clk);
        cfg_wr = '0;
    endtask

    task automatic wr_gs(logic [2:0] code, logic f, logic b, logic [NC-1:0] ex, string r);
        @(negedge clk);
        ctx = r;
        gs_wr = 1'b1; gs_code = code; gs_fall = f; gs_burst = b;
        if (ex != '0) push(cyc + 1, ex, r);
        @(negedge clk);
        gs_wr = 1'b0;
    endtask

    task automatic set_match(int k, logic v, logic [NC-1:0] ex, string r);
        @(negedge clk);
        ctx = r;
        match_in[k] = v;
        if (ex != '0) push(cyc + 1, ex, r);
    endtask

    task automatic set_pin(int k, logic v, logic [NC-1:0] ex, string r);
        @(negedge clk);
        ctx = r;
        pin_async[k] = v;
        if (ex != '0) push(cyc + 3, ex, r);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        idle(4, "R1");
        rst_n = 1'b1;
        idle(2, "R1");

        // R2: code 000 after reset and after an explicit write ignores every source
        for (int k = 0; k < 4; k++) begin
            set_match(k, 1'b1, '0, "R2");
            set_match(k, 1'b0, '0, "R2");
        end
        wr_conv(0, 3'b000, 1'b0, 1'b0, '0, "R2");
        set_match(0, 1'b1, '0, "R2");
        set_match(0, 1'b0, '0, "R2");
        idle(2, "R2");

        // R3: immediate start on one converter only; R12 one cycle wide
        wr_conv(0, 3'b001, 1'b0, 1'b0, 2'b01, "R3");
        idle(4, "R12");
        wr_conv(1, 3'b001, 1'b0, 1'b0, 2'b10, "R3");
        idle(4, "R12");
        // R11: polarity ignored for the immediate code
        wr_conv(0, 3'b001, 1'b1, 1'b0, 2'b01, "R11");
        idle(3, "R11");

        // R4 and R8: each match code with a neighbour toggling first
        for (int k = 0; k < 4; k++) begin
            wr_conv(0, 3'(4 + k), 1'b0, 1'b0, '0, "R4");
            idle(2, "R4");
            set_match((k + 1) % 4, 1'b1, '0, "R4");
            set_match((k + 1) % 4, 1'b0, '0, "R4");
            set_match(k, 1'b1, 2'b01, "R4");
            idle(2, "R12");
            set_match(k, 1'b0, '0, "R5");
            idle(2, "R5");
        end

        // R5: falling polarity on match bit 1
        wr_conv(0, 3'b101, 1'b1, 1'b0, '0, "R5");
        idle(2, "R5");
        set_match(1, 1'b1, '0, "R5");
        set_match(1, 1'b0, 2'b01, "R5");
        idle(3, "R12");

        // R9: a write never produces an edge pulse
        wr_conv(0, 3'b100, 1'b0, 1'b0, '0, "R9");
        set_match(2, 1'b1, '0, "R9");
        idle(2, "R9");
        wr_conv(0, 3'b110, 1'b0, 1'b0, '0, "R9");
        idle(3, "R9");
        set_match(2, 1'b0, '0, "R9");
        wr_conv(0, 3'b110, 1'b1, 1'b0, '0, "R9");
        idle(3, "R9");
        set_match(2, 1'b1, '0, "R9");
        set_match(2, 1'b0, 2'b01, "R9");
        idle(3, "R12");

        // R4 and R8: pin sources, three-cycle latency
        wr_conv(0, 3'b010, 1'b0, 1'b0, '0, "R4");
        set_pin(1, 1'b1, '0, "R4");
        idle(4, "R4");
        set_pin(0, 1'b1, 2'b01, "R8");
        idle(5, "R12");
        set_pin(0, 1'b0, '0, "R5");
        idle(4, "R5");
        set_pin(1, 1'b0, '0, "R4");
        idle(4, "R4");
        wr_conv(0, 3'b011, 1'b0, 1'b0, '0, "R4");
        idle(2, "R4");
        set_pin(1, 1'b1, 2'b01, "R8");
        idle(5, "R12");
        set_pin(1, 1'b0, '0, "R5");
        idle(4, "R5");

        // R6: burst blocks immediate and edge starts
        wr_conv(0, 3'b001, 1'b0, 1'b1, '0, "R6");
        idle(3, "R6");
        wr_conv(0, 3'b100, 1'b0, 1'b1, '0, "R6");
        set_match(0, 1'b1, '0, "R6");
        set_match(0, 1'b0, '0, "R6");
        idle(2, "R6");

        // R10: an edge while busy is dropped and never replayed
        wr_conv(0, 3'b100, 1'b0, 1'b0, '0, "R10");
        conv_busy[0] = 1'b1;
        set_match(0, 1'b1, '0, "R10");
        idle(3, "R10");
        conv_busy[0] = 1'b0;
        idle(4, "R10");
        set_match(0, 1'b0, '0, "R10");
        set_match(0, 1'b1, 2'b01, "R10");
        idle(2, "R12");
        set_match(0, 1'b0, '0, "R10");
        idle(2, "R10");

        // R7: global write loads both converters together
        wr_gs(3'b001, 1'b0, 1'b0, 2'b11, "R7");
        idle(3, "R12");
        wr_gs(3'b111, 1'b0, 1'b0, '0, "R7");
        idle(2, "R7");
        set_match(3, 1'b1, 2'b11, "R7");
        idle(2, "R12");
        set_match(3, 1'b0, '0, "R7");
        // R7: the global write wins over a same-cycle per-converter write
        @(negedge clk);
        ctx = "R7";
        gs_wr = 1'b1; gs_code = 3'b001; gs_fall = 1'b0; gs_burst = 1'b0;
        cfg_wr[1] = 1'b1; cfg_code[5:3] = 3'b000; cfg_burst[1] = 1'b0;
        push(cyc + 1, 2'b11, "R7");
        @(negedge clk);
        gs_wr = 1'b0; cfg_wr = '0;
        idle(3, "R12");
        wr_gs(3'b001, 1'b0, 1'b1, '0, "R6");
        idle(4, "R6");

        if (exp_q.size() != 0) begin
            compared++;
            mismatched++;
            $display("FAIL R12 pending expectations: actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule